// File: doc/BRIEF.md
# RF Front-End Transmit Control Sequencer

This block tells an external RF front-end (power amplifier, low-noise amplifier, antenna switch) whether the transceiver is transmitting. It drives a complementary pin pair for that purpose. It also sequences the internal transmit start-up.

While the PLL is locked and the block is idle, a rising edge on the trigger input starts a transmission. The block then enters its transmit-running state and counts a fixed settling interval in microsecond timebase ticks. Before that interval ends, it switches on the PA buffer and then the PA, each at its own programmable lead time. When the interval expires, it issues a one-clock modulation-start strobe. A frame-done input ends the transmission and returns the block to the locked idle state.

The pin pair is gated by a front-end enable bit. When the enable is clear, both pins sit low whatever the sequencer is doing. This lets the external switches be parked in a low-leakage condition.

Top module: `fe_tx_sequencer`

## Requirements
- R1: With `feEnable` low, `frontTxPin` and `frontRxPin` are both 0 in every state.
- R2: With `feEnable` high and the block in the locked idle state (`stateCode` = 0), `frontTxPin` is 0 and `frontRxPin` is 1.
- R3: With `feEnable` high and the block in the transmit-running state (`stateCode` = 1), `frontTxPin` is 1 and `frontRxPin` is 0.
- R4: A rising edge of `trigIn` sampled at a clock edge while `stateCode` is 0 makes `stateCode` equal 1 from that edge on. The edge is found by comparing the input with a registered copy of itself. State codes: 0 = locked idle, 1 = transmit running.
- R5: A rising edge of `trigIn` while `stateCode` is 1 is ignored. The state stays 1 and the tick count toward modulation start is not disturbed.
- R6: `modStart` is high for exactly one clock. That clock begins at the edge that samples the 16th `usTick` counted since entering the transmit-running state. It is low at all other times.
- R7: `paBufEn` is high in the transmit-running state from the edge that samples tick number 16 − 2·`bufLeadSel` onward. Lead times are 0, 2, 4 or 6 µs for selector values 0 to 3.
- R8: `paEn` is high in the transmit-running state from the edge that samples tick number 16 − 2·(`paLeadSel`+1) onward. Lead times are 2, 4, 6 or 8 µs for selector values 0 to 3.
- R9: `frameDone` high in the transmit-running state forces `paEn` and `paBufEn` low in that same cycle. At the next edge, `stateCode` returns to 0 and the pins return to their idle levels.
- R10: `frameDone` in the locked idle state has no effect. The state stays 0.
- R11: A synchronous active-high `rst` forces `stateCode` to 0 with `paEn`, `paBufEn` and `modStart` low, including when it is applied mid-transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feEnable | input | 1 | Front-end pin pair enable |
| trigIn | input | 1 | Transmit trigger, acts on its rising edge |
| usTick | input | 1 | One-clock pulse per microsecond |
| frameDone | input | 1 | End of the transmitted frame |
| bufLeadSel | input | 2 | PA buffer lead selector (2 µs steps from 0) |
| paLeadSel | input | 2 | PA lead selector (2 µs steps from 2) |
| frontTxPin | output | 1 | Front-end pin, high while transmitting |
| frontRxPin | output | 1 | Front-end pin, high while not transmitting |
| paBufEn | output | 1 | PA buffer enable |
| paEn | output | 1 | PA enable |
| modStart | output | 1 | One-clock modulation start strobe |
| stateCode | output | 2 | 0 = locked idle, 1 = transmit running |

## Verification
The embedded assertions check several rules on every cycle:
- State transitions follow the trigger and frame-done inputs.
- The modulation strobe is a single clock and occurs only at a full settling count.
- Frame-done drops both amplifier enables immediately.
- The PA is never enabled outside a transmission.

The exact tick at which each enable switches on depends on the lead selectors. The pin levels under each enable setting, the immunity of the count to a second trigger, and reset in mid-run are shown only by the bench. It sweeps every lead-selector combination with the enable both set and clear.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_TXRUN  = 2'd1
  } seq_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;  // accepted trigger, entering transmit
    logic stop;   // frame done while transmitting
    logic busy;   // currently in transmit-running state
  } seq_strobe_t;

endpackage

// File: rtl/fe_tx_ctrl.sv
module fe_tx_ctrl
  import fe_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        trigIn,
  input  logic        frameDone,
  output seq_strobe_t strb,
  output seq_state_e  stateQ
);

  logic trigQ;
  logic trigRise;
  seq_state_e stateNext;

  assign trigRise = trigIn & ~trigQ;

  always_ff @(posedge clk) begin
    if (rst) trigQ <= 1'b0;
    else     trigQ <= trigIn;
  end

  always_comb begin
    stateNext  = stateQ;
    strb.start = 1'b0;
    strb.stop  = 1'b0;
    strb.busy  = (stateQ == ST_TXRUN);
    case (stateQ)
      ST_LOCKED: begin
        if (trigRise) begin
          strb.start = 1'b1;
          stateNext  = ST_TXRUN;
        end
      end
      ST_TXRUN: begin
        if (frameDone) begin
          strb.stop = 1'b1;
          stateNext = ST_LOCKED;
        end
      end
      default: stateNext = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_LOCKED;
    else     stateQ <= stateNext;
  end

  // R4: accepted rising edge moves to transmit
  p_rise_starts_r4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_LOCKED && trigIn && !trigQ) |=> (stateQ == ST_TXRUN));

  // R5: transmit persists regardless of trigger activity
  p_busy_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_TXRUN && !frameDone) |=> (stateQ == ST_TXRUN));

  // R9: frame done returns to locked idle
  p_done_returns_r9: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_TXRUN && frameDone) |=> (stateQ == ST_LOCKED));

  // R10: idle without a rising edge stays idle
  p_idle_stays_r10: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_LOCKED && !(trigIn && !trigQ)) |=> (stateQ == ST_LOCKED));

endmodule

// File: rtl/fe_tx_datapath.sv
module fe_tx_datapath
  import fe_tx_pkg::*;
#(
  parameter int SETTLE_TICKS = 16,
  parameter int LEAD_STEP    = 2,
  parameter int SEL_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_strobe_t       strb,
  input  logic              usTick,
  input  logic              feEnable,
  input  logic [SEL_W-1:0]  bufLeadSel,
  input  logic [SEL_W-1:0]  paLeadSel,
  output logic              pinTx,
  output logic              pinRx,
  output logic              paBufEn,
  output logic              paEn,
  output logic              modStart
);

  localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam int THR_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SETTLE_TICKS);

  logic [CNT_W-1:0] tickCnt;
  logic [THR_W-1:0] bufThr;
  logic [THR_W-1:0] paThr;
  logic             active;

  // Settling tick counter, cleared outside transmit
  always_ff @(posedge clk) begin
    if (rst || strb.start || strb.stop || !strb.busy)
      tickCnt <= '0;
    else if (usTick && tickCnt != CNT_FULL)
      tickCnt <= tickCnt + 1'b1;
  end

  // One-clock strobe at expiry of the settling count
  always_ff @(posedge clk) begin
    if (rst) modStart <= 1'b0;
    else     modStart <= strb.busy && !strb.stop && usTick && (tickCnt == CNT_LAST);
  end

  always_comb begin
    bufThr = THR_W'(SETTLE_TICKS) - THR_W'(LEAD_STEP) * THR_W'(bufLeadSel);
    paThr  = THR_W'(SETTLE_TICKS) - THR_W'(LEAD_STEP) * (THR_W'(paLeadSel) + 1'b1);
  end

  assign active  = strb.busy && !strb.stop;
  assign paBufEn = active && ({1'b0, tickCnt} >= bufThr);
  assign paEn    = active && ({1'b0, tickCnt} >= paThr);

  // Complementary indicator pair, both low when disabled
  assign pinTx = feEnable &  strb.busy;
  assign pinRx = feEnable & ~strb.busy;

  // R6: strobe lasts one clock
  p_mod_single_r6: assert property (@(posedge clk) disable iff (rst)
    modStart |=> !modStart);

  // R6: strobe only at a full count
  p_mod_full_r6: assert property (@(posedge clk) disable iff (rst)
    modStart |-> (tickCnt == CNT_FULL));

  // R9: stop drops both amplifier enables in the same cycle
  p_stop_drops_r9: assert property (@(posedge clk) disable iff (rst)
    strb.stop |-> (!paEn && !paBufEn));

  // R8: PA never on outside a transmission
  p_pa_busy_r8: assert property (@(posedge clk) disable iff (rst)
    paEn |-> strb.busy);

endmodule

// File: rtl/fe_tx_sequencer.sv
module fe_tx_sequencer
  import fe_tx_pkg::*;
#(
  parameter int SETTLE_TICKS = 16,
  parameter int LEAD_STEP    = 2,
  parameter int SEL_W        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             feEnable,
  input  logic             trigIn,
  input  logic             usTick,
  input  logic             frameDone,
  input  logic [SEL_W-1:0] bufLeadSel,
  input  logic [SEL_W-1:0] paLeadSel,
  output logic             frontTxPin,
  output logic             frontRxPin,
  output logic             paBufEn,
  output logic             paEn,
  output logic             modStart,
  output logic [1:0]       stateCode
);

  seq_strobe_t strb;
  seq_state_e  stateQ;

  fe_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .trigIn    (trigIn),
    .frameDone (frameDone),
    .strb      (strb),
    .stateQ    (stateQ)
  );

  fe_tx_datapath #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .LEAD_STEP    (LEAD_STEP),
    .SEL_W        (SEL_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .usTick     (usTick),
    .feEnable   (feEnable),
    .bufLeadSel (bufLeadSel),
    .paLeadSel  (paLeadSel),
    .pinTx      (frontTxPin),
    .pinRx      (frontRxPin),
    .paBufEn    (paBufEn),
    .paEn       (paEn),
    .modStart   (modStart)
  );

  assign stateCode = stateQ;

endmodule

// File: tb/fe_tx_sequencer_test.sv
`timescale 1ns/1ps
module fe_tx_sequencer_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic feEnable = 1'b0;
  logic trigIn = 1'b0;
  logic usTick = 1'b0;
  logic frameDone = 1'b0;
  logic [1:0] bufLeadSel = '0;
  logic [1:0] paLeadSel = '0;
  logic frontTxPin, frontRxPin, paBufEn, paEn, modStart;
  logic [1:0] stateCode;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  fe_tx_sequencer uut (
    .clk(clk), .rst(rst), .feEnable(feEnable), .trigIn(trigIn),
    .usTick(usTick), .frameDone(frameDone), .bufLeadSel(bufLeadSel),
    .paLeadSel(paLeadSel), .frontTxPin(frontTxPin), .frontRxPin(frontRxPin),
    .paBufEn(paBufEn), .paEn(paEn), .modStart(modStart), .stateCode(stateCode)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (buf=%0d pa=%0d en=%0b)",
               req, act, exp, bufLeadSel, paLeadSel, feEnable);
    end
  endtask

  // Pin levels for a given state: R1 when disabled, R2/R3 when enabled
  task automatic chkPins(input int busy);
    if (!feEnable) begin
      chk("R1 tx pin", int'(frontTxPin), 0);
      chk("R1 rx pin", int'(frontRxPin), 0);
    end else if (busy != 0) begin
      chk("R3 tx pin", int'(frontTxPin), 1);
      chk("R3 rx pin", int'(frontRxPin), 0);
    end else begin
      chk("R2 tx pin", int'(frontTxPin), 0);
      chk("R2 rx pin", int'(frontRxPin), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rst = 1'b0;
    // R11: reset state
    chk("R11 state", int'(stateCode), 0);
    chk("R11 paEn", int'(paEn), 0);
    chk("R11 paBufEn", int'(paBufEn), 0);
    chk("R11 modStart", int'(modStart), 0);

    for (int en = 0; en < 2; en++) begin
      for (int b = 0; b < 4; b++) begin
        for (int p = 0; p < 4; p++) begin
          feEnable   = en[0];
          bufLeadSel = b[1:0];
          paLeadSel  = p[1:0];
          cyc();
          chk("R4 idle code", int'(stateCode), 0);
          chkPins(0);
          // R4: rising edge while idle
          trigIn = 1'b1;
          cyc();
          chk("R4 enter tx", int'(stateCode), 1);
          chk("R6 no early strobe", int'(modStart), 0);
          chkPins(1);
          for (int k = 1; k <= 18; k++) begin
            if (k == 6) trigIn = 1'b0;
            if (k == 7) trigIn = 1'b1;  // R5: second rising edge in tx
            usTick = 1'b1;
            cyc();
            usTick = 1'b0;
            chk("R5 stays tx", int'(stateCode), 1);
            chk("R6 strobe", int'(modStart), (k == 16) ? 1 : 0);
            chk("R7 buffer", int'(paBufEn), (k >= 16 - 2 * b) ? 1 : 0);
            chk("R8 pa", int'(paEn), (k >= 16 - 2 * (p + 1)) ? 1 : 0);
            chkPins(1);
            cyc();
            chk("R6 strobe gap", int'(modStart), 0);
          end
          trigIn = 1'b0;
          // R9: frame done drops enables in the same cycle
          frameDone = 1'b1;
          #1;
          chk("R9 pa same cycle", int'(paEn), 0);
          chk("R9 buffer same cycle", int'(paBufEn), 0);
          cyc();
          frameDone = 1'b0;
          chk("R9 back idle", int'(stateCode), 0);
          chkPins(0);
          // R10: frame done while idle ignored
          frameDone = 1'b1;
          cyc();
          frameDone = 1'b0;
          chk("R10 idle kept", int'(stateCode), 0);
          chk("R10 pa off", int'(paEn), 0);
          chkPins(0);
        end
      end
    end

    // R11: reset in mid-transmission
    feEnable = 1'b1;
    bufLeadSel = 2'd3;
    paLeadSel = 2'd3;
    trigIn = 1'b1;
    cyc();
    for (int k = 0; k < 12; k++) begin
      usTick = 1'b1;
      cyc();
      usTick = 1'b0;
    end
    chk("R11 pre-reset pa", int'(paEn), 1);
    rst = 1'b1;
    cyc();
    chk("R11 mid state", int'(stateCode), 0);
    chk("R11 mid pa", int'(paEn), 0);
    chk("R11 mid buffer", int'(paBufEn), 0);
    chk("R11 mid strobe", int'(modStart), 0);
    rst = 1'b0;
    trigIn = 1'b0;
    cyc();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule